// File: doc/BRIEF.md
# Indexed RTC Register Port with Interrupt Flags

This block is the host side of a real-time-clock register bank of 128 bytes, reached through two byte addresses. A write to the even address selects one of the 128 bytes. An access to the odd address then reads or writes the selected byte. Most bytes are plain storage. Four control bytes at indexes 10 to 13 (0x0A to 0x0D) have special behaviour:

- **Control A (0x0A)**: holds the divider and rate settings, plus a read-only update-in-progress bit.
- **Control B (0x0B)**: holds the interrupt enables and the SET bit.
- **Flags C (0x0C)**: holds the interrupt flags and is cleared when read.
- **Status D (0x0D)**: fixed at 0x80.

The timing blocks around the port raise single-cycle pulses when a periodic tick, an alarm match or an update end occurs. They also pulse when an update window opens. The port latches these events as flags and drives a level interrupt line from them. It exports the two control bytes to the timing logic. It also emits a one-cycle pulse when a divider reset is lifted, so that the timekeeping logic can place the first update half a second later.

Top module: `rtc_regport`

## Requirements
- R1: A write with `bus_addr`=0 sets the index to `bus_wdata[6:0]`, and bit 7 of the data is ignored.
- R2: A write with `bus_addr`=1 stores the byte at the index. A read with `bus_addr`=1 returns the indexed byte on `bus_rdata` one cycle after the strobe. A read with `bus_addr`=0 returns 0xFF.
- R3: After reset, A reads 0x26, B reads 0x02, C reads 0x00, D reads 0x80, and `irq` is low. Reset therefore leaves every enable and every flag clear.
- R4: Bit 7 of A (UIP) is read-only. A host write to A changes only bits 6:0. UIP is set by `upd_begin` while the clock is running, which means B bit 7 is 0 and A bits 6:4 are at most 3'b010. UIP is cleared by `uf_set`.
- R5: A read of C returns its current value, then clears all of C and drops `irq`.
- R6: Host writes to C and D are ignored.
- R7: On a write to B, C bit 7 (IRQF) and `irq` are set at once if any written enable matches a pending flag. The enables are bit 6 for periodic, bit 5 for alarm and bit 4 for update; the matching flags are C bits 6, 5 and 4. If no enable matches, IRQF and `irq` are cleared.
- R8: Writing B with bit 7 (SET) high clears UIP. Writing A with bits 6:5 equal to 2'b11 (divider reset) also clears UIP.
- R9: `pf_set`, `af_set` and `uf_set` set C bits 6, 5 and 4. IRQF and `irq` follow only when the matching enable in B is set.
- R10: A write to A that moves bits 6:5 away from 2'b11 to a running value (bits 6:4 at most 3'b010) while SET is 0 produces exactly one `half_start` pulse. Otherwise no pulse is produced.
- R11: A flag pulse that arrives in the same cycle as a read of C is not lost. That read returns the old value, and the next read shows the new flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 selects the index, 1 selects the data byte |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| pf_set | input | 1 | Periodic tick pulse |
| af_set | input | 1 | Alarm match pulse |
| uf_set | input | 1 | Update end pulse |
| upd_begin | input | 1 | Update window start pulse |
| bus_rdata | output | 8 | Read data, registered |
| irq | output | 1 | Level interrupt line, equal to IRQF |
| ctl_a | output | 8 | Current control A byte |
| ctl_b | output | 8 | Current control B byte |
| half_start | output | 1 | Pulse when a divider reset is lifted |

## Verification
The functions that collide are the read-to-clear of C and a flag pulse from the timing side. A collision can also occur between a write to B and a flag pulse. The bench provokes the first collision by raising `pf_set` in the very cycle of a C read strobe. It judges the result through the scoreboard: the first read must return the old byte, and a second read must return 0x40. It also checks that a B write which enables an already pending flag drives `irq` high in the following cycle, before any other event can intervene.

// File: rtl/rtc_regport.sv
module rtc_regport #(
  parameter int IDX_W = 7,
  parameter int DW    = 8,
  parameter int IX_A  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          pf_set,
  input  logic          af_set,
  input  logic          uf_set,
  input  logic          upd_begin,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic [DW-1:0] ctl_a,
  output logic [DW-1:0] ctl_b,
  output logic          half_start
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] IX_B = IDX_W'(IX_A + 1);
  localparam logic [IDX_W-1:0] IX_C = IDX_W'(IX_A + 2);
  localparam logic [IDX_W-1:0] IX_D = IDX_W'(IX_A + 3);
  localparam logic [DW-1:0] D_VAL = 8'h80;

  logic [DW-1:0]    ram [DEPTH];
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    reg_a, reg_b, reg_c;

  logic wr_d, rd_d, wr_a, wr_b, rd_c, running;
  logic [2:0] set_v, en_now, flags_n;
  logic uip_n, irqf_n;

  assign wr_d    = bus_wr && bus_addr;
  assign rd_d    = bus_rd && bus_addr;
  assign wr_a    = wr_d && idx == IDX_W'(IX_A);
  assign wr_b    = wr_d && idx == IX_B;
  assign rd_c    = rd_d && idx == IX_C;
  assign running = !reg_b[7] && reg_a[6:4] <= 3'd2;
  assign set_v   = {pf_set, af_set, uf_set};
  assign en_now  = wr_b ? bus_wdata[6:4] : reg_b[6:4];
  assign flags_n = (rd_c ? 3'b000 : reg_c[6:4]) | set_v;

  always_comb begin
    if (wr_b)      irqf_n = |(en_now & flags_n);
    else if (rd_c) irqf_n = |(set_v & en_now);
    else           irqf_n = reg_c[7] | (|(set_v & en_now));
    if (wr_b && bus_wdata[7])                uip_n = 1'b0;
    else if (wr_a && bus_wdata[6:5] == 2'b11) uip_n = 1'b0;
    else if (uf_set)                          uip_n = 1'b0;
    else if (upd_begin && running)            uip_n = 1'b1;
    else                                      uip_n = reg_a[7];
  end

  always_ff @(posedge clk)
    if (wr_d && idx != IDX_W'(IX_A) && idx != IX_B && idx != IX_C && idx != IX_D)
      ram[idx] <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      reg_a      <= 8'h26;
      reg_b      <= 8'h02;
      reg_c      <= 8'h00;
      bus_rdata  <= '0;
      half_start <= 1'b0;
    end else begin
      if (bus_wr && !bus_addr) idx <= bus_wdata[IDX_W-1:0];
      reg_a[7]   <= uip_n;
      if (wr_a) reg_a[6:0] <= bus_wdata[6:0];
      if (wr_b) reg_b <= bus_wdata;
      reg_c      <= {irqf_n, flags_n, 4'h0};
      half_start <= wr_a && reg_a[6:5] == 2'b11 && bus_wdata[6:4] <= 3'd2 && !reg_b[7];
      if (bus_rd) begin
        if (!bus_addr)                     bus_rdata <= 8'hFF;
        else if (idx == IDX_W'(IX_A))      bus_rdata <= reg_a;
        else if (idx == IX_B)              bus_rdata <= reg_b;
        else if (idx == IX_C)              bus_rdata <= reg_c;
        else if (idx == IX_D)              bus_rdata <= D_VAL;
        else                               bus_rdata <= ram[idx];
      end
    end
  end

  assign irq   = reg_c[7];
  assign ctl_a = reg_a;
  assign ctl_b = reg_b;

  p_irq_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && set_v == 3'b000) |=> !irq);
  p_uip_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && bus_wdata[6:5] != 2'b11 && !upd_begin && !uf_set) |=> ctl_a[7] == $past(ctl_a[7]));
  p_set_uip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && bus_wdata[7]) |=> !ctl_a[7]);
  p_irq_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && (|(bus_wdata[6:4] & reg_c[6:4]))) |=> irq);
  p_flag_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && pf_set) |=> reg_c[6]);
  p_half_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    half_start |=> !half_start);
endmodule

// File: tb/sim_rtc_regport.sv
`timescale 1ns/1ps
module sim_rtc_regport;
  logic clk = 0, rst_n = 0;
  logic bus_addr = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic pf_set = 0, af_set = 0, uf_set = 0, upd_begin = 0;
  logic [7:0] bus_rdata, ctl_a, ctl_b;
  logic irq, half_start;
  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic rd_seen = 0;

  always #4 clk = ~clk;

  rtc_regport u0 (.clk, .rst_n, .bus_addr, .bus_wdata, .bus_wr, .bus_rd,
    .pf_set, .af_set, .uf_set, .upd_begin, .bus_rdata, .irq, .ctl_a, .ctl_b, .half_start);

  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) if (rd_seen) begin
    if (exp_q.size() == 0) begin
      n_chk++; n_bad++; $display("FAIL monitor: read with no expected item");
    end else begin
      logic [7:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e) begin
        n_bad++; $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string t);
    n_chk++;
    if (got !== exp) begin n_bad++; $display("FAIL %s: got %b expected %b", t, got, exp); end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic wreg(input logic [7:0] ix, input logic [7:0] d);
    wr(0, ix); wr(1, d);
  endtask

  task automatic rd(input logic a, input logic [7:0] e, input string t);
    @(negedge clk); bus_addr = a; bus_rd = 1; exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rreg(input logic [7:0] ix, input logic [7:0] e, input string t);
    wr(0, ix); rd(1, e, t);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which) 0: pf_set = 1; 1: af_set = 1; 2: uf_set = 1; default: upd_begin = 1; endcase
    @(negedge clk); pf_set = 0; af_set = 0; uf_set = 0; upd_begin = 0;
  endtask

  initial begin
    #20000;
    n_chk++; n_bad++; $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    chk(irq, 0, "R3 irq after reset");
    rreg(8'h0A, 8'h26, "R3 A reset");
    rreg(8'h0B, 8'h02, "R3 B reset");
    rreg(8'h0C, 8'h00, "R3 C reset");
    rreg(8'h0D, 8'h80, "R3 D reset");
    // R1 R2
    wreg(8'h8E, 8'h5A);
    rreg(8'h0E, 8'h5A, "R1 index bit7 ignored");
    wreg(8'h20, 8'h33);
    rreg(8'h20, 8'h33, "R2 data byte");
    rd(0, 8'hFF, "R2 even read");
    // R6
    wreg(8'h0C, 8'hFF); wreg(8'h0D, 8'h00);
    rreg(8'h0C, 8'h00, "R6 C write ignored");
    rreg(8'h0D, 8'h80, "R6 D write ignored");
    chk(irq, 0, "R6 irq stays low");
    // R4 R8
    pulse(3);
    rreg(8'h0A, 8'hA6, "R4 UIP set");
    wreg(8'h0A, 8'h27);
    rreg(8'h0A, 8'hA7, "R4 UIP kept on write");
    wreg(8'h0B, 8'h82);
    rreg(8'h0A, 8'h27, "R8 SET clears UIP");
    wreg(8'h0B, 8'h02);
    // R9 R5
    pulse(0);
    chk(irq, 0, "R9 PF without enable");
    rreg(8'h0C, 8'h40, "R9 PF flag");
    wreg(8'h0B, 8'h22);
    pulse(1);
    chk(irq, 1, "R9 AF with enable");
    rreg(8'h0C, 8'hA0, "R5 C read value");
    chk(irq, 0, "R5 irq dropped");
    rreg(8'h0C, 8'h00, "R5 C cleared");
    // R7
    wreg(8'h0B, 8'h02);
    pulse(2);
    chk(irq, 0, "R7 UF pending no enable");
    wr(1, 8'h42);
    chk(irq, 0, "R7 non-matching enable");
    wr(1, 8'h12);
    chk(irq, 1, "R7 matching enable fires");
    wr(1, 8'h02);
    chk(irq, 0, "R7 enable removed");
    rreg(8'h0C, 8'h10, "R7 IRQF cleared flag kept");
    // R10
    wreg(8'h0A, 8'h66);
    chk(half_start, 0, "R10 no pulse entering reset");
    wr(1, 8'h26);
    chk(half_start, 1, "R10 pulse on release");
    @(negedge clk);
    chk(half_start, 0, "R10 single pulse");
    wreg(8'h0B, 8'h82);
    wreg(8'h0A, 8'h66);
    wr(1, 8'h26);
    chk(half_start, 0, "R10 no pulse while SET");
    wreg(8'h0B, 8'h02);
    // R11
    wr(0, 8'h0C);
    @(negedge clk); bus_addr = 1; bus_rd = 1; pf_set = 1;
    exp_q.push_back(8'h00); tag_q.push_back("R11 collided read old");
    @(negedge clk); bus_rd = 0; pf_set = 0;
    rd(1, 8'h40, "R11 flag survives");
    // R3 reset clears enables and flags
    wreg(8'h0B, 8'h7A);
    pulse(0);
    chk(irq, 1, "R3 irq before reset");
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk(irq, 0, "R3 irq after mid reset");
    rreg(8'h0B, 8'h02, "R3 B after mid reset");
    rreg(8'h0C, 8'h00, "R3 C after mid reset");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++; $display("FAIL scoreboard: %0d reads missing, expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule